// File: doc/BRIEF.md
# Selectable 8 kHz and One-Second Reference Generator

This block turns line-rate clock activity into an 8 kHz reference strobe and then into a one-second strobe. All source clocks arrive as single-cycle enable pulses inside one system clock domain. Each line port has its own stage. That stage picks one of three clock sources: the transmit clock, the receive line-interface clock, or an input clock pin. It then counts the chosen source with a modulus set by the port's framing mode. The modulus is 5592 for the 44.736 MHz rate and 4296 for the 34.368 MHz rate.

A single global stage builds the chip-wide 8 kHz reference. The source can be a synchronised external 8 kHz input, the rate-adapter clock, a dedicated reference pin clock, or any one port's reference. When the external-input control is set, it overrides the 3-bit select. The global reference can be mirrored onto a general-purpose output pin. A further divide-by-8000 stage turns it into the one-second tick.

When a select or mode changes, the counters that depend on it are cleared. This means no shortened period is ever emitted.

Top module: `tref_gen`

## Requirements
- R1: Port source select `port_src` (2 bits per port) picks 0 = transmit clock enable, 1 = receive clock enable, 2 = clock-pin enable; code 3 selects nothing and that port's reference stays low.
- R2: A port counts its selected enable with modulus DS3_MOD (5592) when its `port_e3` bit is 0 and E3_MOD (4296) when it is 1. It emits a one-cycle strobe in the cycle after the enable pulse that wraps the count from modulus-1 to 0.
- R3: With `ext_pick` low, `glob_src` 0 divides the rate-adapter enable and 1 divides the reference-pin enable, both with the modulus chosen by `adapt_e3` (0 → DS3_MOD, 1 → E3_MOD). Code 2+i passes port i's reference. `glob_8k` follows its source one cycle later.
- R4: With `ext_pick` low, a `glob_src` code of 2+NPORT or above forces `glob_8k` low.
- R5: With `ext_pick` high, `ext_8k_in` passes through a two-flop synchroniser. Each rising edge gives one `glob_8k` pulse three clock edges after the input changes.
- R6: `gpo_8k` copies `glob_8k` while `pin_out_en` is high and is low otherwise.
- R7: `sec_tick` pulses once for every SEC_MOD (8000) `glob_8k` pulses, one cycle after the pulse that completes the count.
- R8: A change of a port's select or mode clears that port's counter. A change of `ext_pick`, `glob_src` or `adapt_e3` clears the global and one-second counters. Enable pulses arriving in the change cycle are not counted.
- R9: While `rst` is high, all outputs are 0 and every counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk_en | input | NPORT | Per-port transmit clock enable pulses |
| rx_clk_en | input | NPORT | Per-port receive line-interface clock enable pulses |
| pin_clk_en | input | NPORT | Per-port input clock pin enable pulses |
| port_e3 | input | NPORT | Per-port framing mode: 0 = DS3 rate, 1 = E3 rate |
| port_src | input | 2*NPORT | Per-port source select, port i in bits [2i+1:2i] |
| adapt_clk_en | input | 1 | Rate-adapter clock enable pulses |
| refpin_clk_en | input | 1 | Reference pin clock enable pulses |
| adapt_e3 | input | 1 | Rate of the global clock source: 0 = DS3, 1 = E3 |
| ext_8k_in | input | 1 | External 8 kHz level input (asynchronous) |
| ext_pick | input | 1 | Take the global reference from the external input |
| glob_src | input | 3 | Global source select |
| pin_out_en | input | 1 | Drive the global reference to `gpo_8k` |
| port_8k | output | NPORT | Per-port 8 kHz strobes |
| glob_8k | output | 1 | Global 8 kHz strobe |
| gpo_8k | output | 1 | Global reference on the output pin |
| sec_tick | output | 1 | One-second strobe |

## Verification
The three port sources are driven together with different densities: one pulse every step, every second step and every third step. With both moduli applied, each combination of source and mode gives a different strobe count, so a wrong mux leg or a wrong modulus shows up as a wrong count. The global select is walked through the adapter clock, the reference pin, both ports, an unused code and the external input. The one-second count and the output-pin count are checked alongside each case. Directed tests pin down the exact latency of a port wrap and of an external edge. A further test changes the mode mid-count, where a counter that was not cleared would emit an early strobe.

// File: rtl/tref_pkg.sv
package tref_pkg;
  typedef enum logic [1:0] {
    PSRC_TX  = 2'd0,
    PSRC_RX  = 2'd1,
    PSRC_PIN = 2'd2,
    PSRC_OFF = 2'd3
  } psrc_e;

  typedef enum logic [2:0] {
    GSRC_ADAPT  = 3'd0,
    GSRC_REFPIN = 3'd1
  } gsrc_e;

  localparam int GSRC_PORT_BASE = 2;
endpackage

// File: rtl/tref_div.sv
module tref_div #(
  parameter int MOD_A = 5592,
  parameter int MOD_B = 4296
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic use_b,
  output logic stb
);
  localparam int MOD_MAX = (MOD_A > MOD_B) ? MOD_A : MOD_B;
  localparam int CW      = $clog2(MOD_MAX);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = use_b ? CW'(MOD_B - 1) : CW'(MOD_A - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      stb <= 1'b0;
    end else if (en) begin
      if (cnt == last) begin
        cnt <= '0;
        stb <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        stb <= 1'b0;
      end
    end else begin
      stb <= 1'b0;
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst || clr)
    cnt <= last);

  assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !stb));
endmodule

// File: rtl/tref_sync.sv
module tref_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], din};
  end

  assign rise = sh[1] & ~sh[2];

  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tref_port.sv
module tref_port
  import tref_pkg::*;
#(
  parameter int DS3_MOD = 5592,
  parameter int E3_MOD  = 4296
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       pin_en,
  input  logic [1:0] sel,
  input  logic       mode,
  output logic       ref_stb
);
  logic [1:0] sel_q;
  logic       mode_q;
  logic       chg;
  logic       src_en;

  always_ff @(posedge clk) begin
    sel_q  <= sel;
    mode_q <= mode;
  end

  assign chg = !rst && ((sel != sel_q) || (mode != mode_q));

  always_comb begin
    unique case (psrc_e'(sel))
      PSRC_TX:  src_en = tx_en;
      PSRC_RX:  src_en = rx_en;
      PSRC_PIN: src_en = pin_en;
      default:  src_en = 1'b0;
    endcase
  end

  tref_div #(.MOD_A(DS3_MOD), .MOD_B(E3_MOD)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (chg),
    .en   (src_en),
    .use_b(mode),
    .stb  (ref_stb)
  );

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (sel == PSRC_OFF) |=> !ref_stb);
endmodule

// File: rtl/tref_gen.sv
module tref_gen
  import tref_pkg::*;
#(
  parameter int NPORT   = 2,
  parameter int DS3_MOD = 5592,
  parameter int E3_MOD  = 4296,
  parameter int SEC_MOD = 8000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   tx_clk_en,
  input  logic [NPORT-1:0]   rx_clk_en,
  input  logic [NPORT-1:0]   pin_clk_en,
  input  logic [NPORT-1:0]   port_e3,
  input  logic [2*NPORT-1:0] port_src,
  input  logic               adapt_clk_en,
  input  logic               refpin_clk_en,
  input  logic               adapt_e3,
  input  logic               ext_8k_in,
  input  logic               ext_pick,
  input  logic [2:0]         glob_src,
  input  logic               pin_out_en,
  output logic [NPORT-1:0]   port_8k,
  output logic               glob_8k,
  output logic               gpo_8k,
  output logic               sec_tick
);
  localparam int CFG_W = 5;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    tref_port #(.DS3_MOD(DS3_MOD), .E3_MOD(E3_MOD)) u_port (
      .clk    (clk),
      .rst    (rst),
      .tx_en  (tx_clk_en[g]),
      .rx_en  (rx_clk_en[g]),
      .pin_en (pin_clk_en[g]),
      .sel    (port_src[2*g +: 2]),
      .mode   (port_e3[g]),
      .ref_stb(port_8k[g])
    );
  end

  logic [CFG_W-1:0] cfg, cfg_q;
  logic             gchg;

  assign cfg = {ext_pick, adapt_e3, glob_src};

  always_ff @(posedge clk) cfg_q <= cfg;

  assign gchg = !rst && (cfg != cfg_q);

  logic gdiv_en, gdiv_stb, ext_rise, glob_next;

  always_comb begin
    unique case (glob_src)
      GSRC_ADAPT:  gdiv_en = adapt_clk_en;
      GSRC_REFPIN: gdiv_en = refpin_clk_en;
      default:     gdiv_en = 1'b0;
    endcase
  end

  tref_div #(.MOD_A(DS3_MOD), .MOD_B(E3_MOD)) u_gdiv (
    .clk  (clk),
    .rst  (rst),
    .clr  (gchg),
    .en   (gdiv_en),
    .use_b(adapt_e3),
    .stb  (gdiv_stb)
  );

  tref_sync u_sync (
    .clk (clk),
    .rst (rst),
    .din (ext_8k_in),
    .rise(ext_rise)
  );

  always_comb begin
    glob_next = 1'b0;
    if (ext_pick) begin
      glob_next = ext_rise;
    end else if (glob_src == GSRC_ADAPT || glob_src == GSRC_REFPIN) begin
      glob_next = gdiv_stb;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (int'(glob_src) == GSRC_PORT_BASE + i) glob_next = port_8k[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_8k <= 1'b0;
      gpo_8k  <= 1'b0;
    end else begin
      glob_8k <= glob_next;
      gpo_8k  <= glob_next & pin_out_en;
    end
  end

  tref_div #(.MOD_A(SEC_MOD), .MOD_B(SEC_MOD)) u_sec (
    .clk  (clk),
    .rst  (rst),
    .clr  (gchg),
    .en   (glob_8k),
    .use_b(1'b0),
    .stb  (sec_tick)
  );

  assert_unused_low_R4: assert property (@(posedge clk) disable iff (rst)
    (!ext_pick && int'(glob_src) >= GSRC_PORT_BASE + NPORT) |=> !glob_8k);

  assert_gpo_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !pin_out_en |=> !gpo_8k);

  assert_gpo_copy_R6: assert property (@(posedge clk) disable iff (rst)
    pin_out_en |=> (gpo_8k == glob_8k));

  assert_sec_follows_R7: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(glob_8k));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!glob_8k && !gpo_8k && !sec_tick && port_8k == '0));
endmodule

// File: tb/tref_gen_test.sv
module tref_gen_test;
  localparam int NP   = 2;
  localparam int DMOD = 7;
  localparam int EMOD = 5;
  localparam int SMOD = 4;
  localparam int STEPS = 105;

  typedef struct packed {
    logic [1:0] psel;
    logic       pe3;
    logic [2:0] gsel;
    logic       ce3;
    logic       ext;
    logic       oe;
    logic [7:0] ep;
    logic [7:0] eg;
    logic [7:0] egpo;
    logic [7:0] es;
  } vec_t;

  // pulse densities per run: tx 105, rx 53, pin 35, adapter 105, ref pin 35, ext edges 18
  localparam vec_t VT [7] = '{
    '{2'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 8'd15, 8'd15, 8'd15, 8'd3},
    '{2'd1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 8'd10, 8'd10, 8'd0,  8'd2},
    '{2'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 8'd5,  8'd21, 8'd21, 8'd5},
    '{2'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 8'd21, 8'd5,  8'd5,  8'd1},
    '{2'd3, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 8'd0,  8'd15, 8'd15, 8'd3},
    '{2'd1, 1'b0, 3'd6, 1'b0, 1'b0, 1'b1, 8'd7,  8'd0,  8'd0,  8'd0},
    '{2'd2, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 8'd7,  8'd18, 8'd18, 8'd4}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   tx_clk_en = '0, rx_clk_en = '0, pin_clk_en = '0, port_e3 = '0;
  logic [2*NP-1:0] port_src = '0;
  logic            adapt_clk_en = 1'b0, refpin_clk_en = 1'b0, adapt_e3 = 1'b0;
  logic            ext_8k_in = 1'b0, ext_pick = 1'b0, pin_out_en = 1'b0;
  logic [2:0]      glob_src = 3'd2;
  logic [NP-1:0]   port_8k;
  logic            glob_8k, gpo_8k, sec_tick;

  int n_chk = 0, n_bad = 0;
  int n_p0 = 0, n_g = 0, n_gpo = 0, n_s = 0;

  always #5 clk = ~clk;

  tref_gen #(.NPORT(NP), .DS3_MOD(DMOD), .E3_MOD(EMOD), .SEC_MOD(SMOD)) uut (
    .clk(clk), .rst(rst), .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en),
    .pin_clk_en(pin_clk_en), .port_e3(port_e3), .port_src(port_src),
    .adapt_clk_en(adapt_clk_en), .refpin_clk_en(refpin_clk_en), .adapt_e3(adapt_e3),
    .ext_8k_in(ext_8k_in), .ext_pick(ext_pick), .glob_src(glob_src),
    .pin_out_en(pin_out_en), .port_8k(port_8k), .glob_8k(glob_8k),
    .gpo_8k(gpo_8k), .sec_tick(sec_tick)
  );

  always @(negedge clk) begin
    n_p0  += int'(port_8k[0]);
    n_g   += int'(glob_8k);
    n_gpo += int'(gpo_8k);
    n_s   += int'(sec_tick);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] psel, input logic pe3, input logic [2:0] gsel,
                          input logic ce3, input logic ext, input logic oe);
    @(negedge clk);
    rst = 1'b1;
    ext_8k_in = 1'b0;
    port_src = {2'd0, psel};
    port_e3 = {1'b0, pe3};
    glob_src = gsel;
    adapt_e3 = ce3;
    ext_pick = ext;
    pin_out_en = oe;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_run(input logic drive_ext);
    for (int i = 0; i < STEPS; i++) begin
      @(negedge clk);
      tx_clk_en = '1;
      rx_clk_en = {NP{(i % 2) == 0}};
      pin_clk_en = {NP{(i % 3) == 0}};
      adapt_clk_en = 1'b1;
      refpin_clk_en = (i % 3) == 0;
      if (drive_ext) ext_8k_in = (i % 6) < 3;
      @(negedge clk);
      tx_clk_en = '0;
      rx_clk_en = '0;
      pin_clk_en = '0;
      adapt_clk_en = 1'b0;
      refpin_clk_en = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic drive_tx(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      tx_clk_en = '1;
      @(negedge clk);
      tx_clk_en = '0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int b0, b1, b2, b3;

    // R9: pulses during reset must not advance anything
    do_reset(2'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    b0 = n_p0;
    drive_tx(DMOD * 2);
    chk("R9 port strobes in reset", n_p0 - b0, 0);
    chk("R9 glob_8k in reset", int'(glob_8k), 0);
    chk("R9 gpo_8k in reset", int'(gpo_8k), 0);
    chk("R9 sec_tick in reset", int'(sec_tick), 0);
    chk("R9 port_8k in reset", int'(port_8k), 0);

    // vector table: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 7; v++) begin
      do_reset(VT[v].psel, VT[v].pe3, VT[v].gsel, VT[v].ce3, VT[v].ext, VT[v].oe);
      b0 = n_p0; b1 = n_g; b2 = n_gpo; b3 = n_s;
      pulse_run(VT[v].ext);
      chk($sformatf("R1 R2 port0 count vec%0d", v), n_p0 - b0, int'(VT[v].ep));
      chk($sformatf("R3 R4 R5 glob count vec%0d", v), n_g - b1, int'(VT[v].eg));
      chk($sformatf("R6 gpo count vec%0d", v), n_gpo - b2, int'(VT[v].egpo));
      chk($sformatf("R7 sec count vec%0d", v), n_s - b3, int'(VT[v].es));
    end

    // R2 exact wrap latency and one-cycle width, R3 port pass-through delay
    do_reset(2'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1);
    drive_tx(DMOD - 1);
    repeat (3) @(negedge clk);
    chk("R2 no strobe before wrap", int'(port_8k[0]), 0);
    @(negedge clk);
    tx_clk_en = '1;
    @(negedge clk);
    tx_clk_en = '0;
    chk("R2 strobe after wrap pulse", int'(port_8k[0]), 1);
    chk("R3 glob not yet", int'(glob_8k), 0);
    @(negedge clk);
    chk("R2 strobe one cycle wide", int'(port_8k[0]), 0);
    chk("R3 glob one cycle after port", int'(glob_8k), 1);

    // R8: mode change mid-count clears the counter
    do_reset(2'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1);
    b0 = n_p0;
    drive_tx(4);
    @(negedge clk);
    port_e3[0] = 1'b1;
    repeat (2) @(negedge clk);
    drive_tx(EMOD - 2);
    repeat (4) @(negedge clk);
    chk("R8 no early strobe after mode change", n_p0 - b0, 0);
    drive_tx(2);
    repeat (4) @(negedge clk);
    chk("R8 full period after clear", n_p0 - b0, 1);

    // R5: external edge latency
    do_reset(2'd0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1);
    ext_8k_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 glob low two edges after input", int'(glob_8k), 0);
    @(negedge clk);
    chk("R5 glob high three edges after input", int'(glob_8k), 1);
    chk("R6 gpo mirrors glob", int'(gpo_8k), 1);
    @(negedge clk);
    chk("R5 single pulse per edge", int'(glob_8k), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule